// File: doc/BRIEF.md
# Grouped-Priority Interrupt Arbiter

This block sits between a set of interrupt request lines and a processor stub. For every line it holds an enable bit, a pending bit, an active bit and a four-bit priority value. Smaller priority values are more urgent. A global grouping setting decides how many of the upper priority bits form the preemption level. The remaining lower bits form a subpriority that orders waiting requests but never allows one handler to interrupt another.

Software reaches the block through a single-cycle write port: an operation code, a line number and a data byte. It reads any line's state back through a combinational read port. The read port splits the stored priority with a grouping value that the caller supplies. Toward the processor the block raises a request with the number of the winning line. An acknowledge pulse moves that line from pending to active. A completion pulse retires the most recently accepted line, so nested handlers unwind in last-in, first-out order.

Top module: `irq_arb`

## Requirements
- R1: After reset every enable, pending and active bit is 0, every stored priority is 0, the grouping is 0 and `req_o` is low.
- R2: Write operations act on the line given by `wr_id` and take effect at the next clock edge. The operation codes are 0 enable, 1 disable, 2 set pending and 3 clear pending. The read port shows the enable, pending and active bits of line `rd_id`.
- R3: A high `irq_i[i]` sets the pending bit of line i whether or not the line is enabled. A disabled line never wins, and `req_o` stays low when only disabled lines are pending.
- R4: Among pending, enabled lines the winner has the smallest preemption value, then the smallest subpriority, then the lowest line number.
- R5: Operation 4 stores a priority from `wr_data[3:0]` (preemption value) and `wr_data[7:4]` (subpriority). The preemption value keeps G bits and goes in the top G bits of the stored value; the subpriority keeps 4-G bits and fills the rest, where G is the current grouping. The read port returns the stored value shifted right by 4-`rd_group` as the preemption value, and its low 4-`rd_group` bits as the subpriority.
- R6: An acknowledge while `req_o` is high clears the winner's pending bit and sets its active bit at the same edge. An acknowledge while `req_o` is low changes nothing.
- R7: `req_o` is high while handlers are active only if the winner's preemption value is strictly lower than the preemption value of every active line. An equal value never nests.
- R8: With grouping 0 no request is raised while any line is active.
- R9: A completion pulse clears the active bit of the line accepted most recently among those still active. The earlier active lines stay active.
- R10: Operation 5 sets the grouping from `wr_data[2:0]` when that value is 0 to 4, and ignores larger values. A new grouping governs decisions from the next cycle on, including for handlers that are already active. `grp_o` shows the grouping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_i | input | NUM_IRQ | Request lines, a high level sets pending |
| wr_en | input | 1 | Write strobe |
| wr_op | input | 3 | Write operation code |
| wr_id | input | ID_W | Line addressed by the write |
| wr_data | input | 8 | Write data |
| rd_id | input | ID_W | Line addressed by the read port |
| rd_group | input | 3 | Grouping used to split the read priority |
| rd_en_o | output | 1 | Enable bit of the read line |
| rd_pend_o | output | 1 | Pending bit of the read line |
| rd_act_o | output | 1 | Active bit of the read line |
| rd_pre_o | output | 4 | Preemption part of the read line's priority |
| rd_sub_o | output | 4 | Subpriority part of the read line's priority |
| grp_o | output | 3 | Current grouping |
| req_o | output | 1 | A request may be taken now |
| req_id_o | output | ID_W | Winning line |
| ack_i | input | 1 | Processor accepts the winner |
| done_i | input | 1 | Processor finished the newest handler |

## Verification
The request outputs are combinational from the registered state. A corrupted pending, enable or priority bit therefore shows on `req_o` or `req_id_o` in the cycle after the write or acknowledge that caused it. A wrong entry in the acceptance stack stays hidden until the next completion pulse. At that point the wrong active bit clears, and a request that should be blocked may appear, or one that should appear may stay blocked. The bench therefore reads the active bits after every completion and checks the request against the remaining preemption floor.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
    localparam int PRIO_W = 4;
    localparam int GRP_W  = 3;

    typedef logic [PRIO_W-1:0] prio_t;
    typedef logic [GRP_W-1:0]  grp_t;

    typedef enum logic [2:0] {
        OP_EN_SET  = 3'd0,
        OP_EN_CLR  = 3'd1,
        OP_PND_SET = 3'd2,
        OP_PND_CLR = 3'd3,
        OP_PRIO    = 3'd4,
        OP_GROUP   = 3'd5
    } op_e;

    function automatic grp_t clamp_grp(grp_t g);
        return (g > grp_t'(PRIO_W)) ? grp_t'(PRIO_W) : g;
    endfunction

    // preemption level: upper G bits of the stored value
    function automatic prio_t pre_of(prio_t p, grp_t g);
        grp_t sh;
        sh = grp_t'(PRIO_W) - clamp_grp(g);
        return prio_t'({1'b0, p} >> sh);
    endfunction

    // subpriority: lower (4-G) bits
    function automatic prio_t sub_of(prio_t p, grp_t g);
        grp_t       sh;
        logic [4:0] m;
        sh = grp_t'(PRIO_W) - clamp_grp(g);
        m  = (5'd1 << sh) - 5'd1;
        return p & m[3:0];
    endfunction

    function automatic prio_t pack_prio(prio_t pre, prio_t sub, grp_t g);
        grp_t       gg;
        grp_t       sh;
        logic [4:0] pm;
        logic [4:0] sm;
        logic [4:0] hi;
        gg = clamp_grp(g);
        sh = grp_t'(PRIO_W) - gg;
        pm = (5'd1 << gg) - 5'd1;
        sm = (5'd1 << sh) - 5'd1;
        hi = {1'b0, pre & pm[3:0]} << sh;
        return hi[3:0] | (sub & sm[3:0]);
    endfunction
endpackage

// File: rtl/irq_arb_select.sv
module irq_arb_select
    import irq_arb_pkg::*;
#(
    parameter int NUM_IRQ = 8,
    localparam int ID_W   = $clog2(NUM_IRQ)
) (
    input  logic [NUM_IRQ-1:0]        cand,
    input  logic [NUM_IRQ*PRIO_W-1:0] prio,
    output logic                      valid,
    output logic [ID_W-1:0]           win_id,
    output prio_t                     win_prio
);
    // stored value orders preemption first then subpriority; scanning
    // upward with a strict compare keeps the lowest line on ties
    always_comb begin
        valid    = 1'b0;
        win_id   = '0;
        win_prio = '1;
        for (int i = 0; i < NUM_IRQ; i++) begin
            if (cand[i] && (!valid || (prio[i*PRIO_W +: PRIO_W] < win_prio))) begin
                valid    = 1'b1;
                win_id   = ID_W'(i);
                win_prio = prio[i*PRIO_W +: PRIO_W];
            end
        end
    end
endmodule

// File: rtl/irq_arb_gate.sv
module irq_arb_gate
    import irq_arb_pkg::*;
#(
    parameter int NUM_IRQ = 8
) (
    input  logic [NUM_IRQ-1:0]        act,
    input  logic [NUM_IRQ*PRIO_W-1:0] prio,
    input  grp_t                      grp,
    input  prio_t                     win_prio,
    output logic                      may_take
);
    logic  any_act;
    prio_t floor_pre;

    always_comb begin
        any_act   = 1'b0;
        floor_pre = '1;
        for (int i = 0; i < NUM_IRQ; i++) begin
            if (act[i]) begin
                any_act = 1'b1;
                if (pre_of(prio[i*PRIO_W +: PRIO_W], grp) < floor_pre)
                    floor_pre = pre_of(prio[i*PRIO_W +: PRIO_W], grp);
            end
        end
        may_take = !any_act || (pre_of(win_prio, grp) < floor_pre);
    end
endmodule

// File: rtl/irq_arb.sv
module irq_arb
    import irq_arb_pkg::*;
#(
    parameter int NUM_IRQ = 8,
    localparam int ID_W   = $clog2(NUM_IRQ),
    localparam int SP_W   = $clog2(NUM_IRQ + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_IRQ-1:0] irq_i,
    input  logic               wr_en,
    input  logic [2:0]         wr_op,
    input  logic [ID_W-1:0]    wr_id,
    input  logic [7:0]         wr_data,
    input  logic [ID_W-1:0]    rd_id,
    input  logic [2:0]         rd_group,
    output logic               rd_en_o,
    output logic               rd_pend_o,
    output logic               rd_act_o,
    output logic [3:0]         rd_pre_o,
    output logic [3:0]         rd_sub_o,
    output logic [2:0]         grp_o,
    output logic               req_o,
    output logic [ID_W-1:0]    req_id_o,
    input  logic               ack_i,
    input  logic               done_i
);
    typedef struct packed {
        logic [NUM_IRQ-1:0]        en;
        logic [NUM_IRQ-1:0]        pend;
        logic [NUM_IRQ-1:0]        act;
        logic [NUM_IRQ*PRIO_W-1:0] prio;
        grp_t                      grp;
        logic [NUM_IRQ*ID_W-1:0]   stk;
        logic [SP_W-1:0]           sp;
    } state_t;

    state_t s_q, s_d;

    logic            win_valid;
    logic [ID_W-1:0] win_id;
    prio_t           win_prio;
    logic            may_take;

    irq_arb_select #(.NUM_IRQ(NUM_IRQ)) u_select (
        .cand     (s_q.pend & s_q.en),
        .prio     (s_q.prio),
        .valid    (win_valid),
        .win_id   (win_id),
        .win_prio (win_prio)
    );

    irq_arb_gate #(.NUM_IRQ(NUM_IRQ)) u_gate (
        .act      (s_q.act),
        .prio     (s_q.prio),
        .grp      (s_q.grp),
        .win_prio (win_prio),
        .may_take (may_take)
    );

    assign req_o    = win_valid && may_take;
    assign req_id_o = win_id;

    logic [SP_W-1:0] sp_n;
    logic [ID_W-1:0] top_id;

    always_comb begin
        s_d    = s_q;
        sp_n   = s_q.sp;
        top_id = '0;
        if (s_q.sp != '0)
            top_id = s_q.stk[(int'(s_q.sp) - 1)*ID_W +: ID_W];

        if (wr_en) begin
            case (wr_op)
                OP_EN_SET:  s_d.en[wr_id]   = 1'b1;
                OP_EN_CLR:  s_d.en[wr_id]   = 1'b0;
                OP_PND_SET: s_d.pend[wr_id] = 1'b1;
                OP_PND_CLR: s_d.pend[wr_id] = 1'b0;
                OP_PRIO:    s_d.prio[wr_id*PRIO_W +: PRIO_W] =
                                pack_prio(wr_data[3:0], wr_data[7:4], s_q.grp);
                OP_GROUP:   if (wr_data[2:0] <= 3'd4) s_d.grp = wr_data[2:0];
                default: ;
            endcase
        end

        s_d.pend = s_d.pend | irq_i;

        // retire the newest handler first, then accept the winner
        if (done_i && (s_q.sp != '0)) begin
            s_d.act[top_id] = 1'b0;
            sp_n = s_q.sp - SP_W'(1);
        end

        if (ack_i && req_o) begin
            s_d.pend[win_id] = 1'b0;
            s_d.act[win_id]  = 1'b1;
            s_d.stk[int'(sp_n)*ID_W +: ID_W] = win_id;
            sp_n = sp_n + SP_W'(1);
        end
        s_d.sp = sp_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rd_en_o   = s_q.en[rd_id];
    assign rd_pend_o = s_q.pend[rd_id];
    assign rd_act_o  = s_q.act[rd_id];
    assign rd_pre_o  = pre_of(s_q.prio[rd_id*PRIO_W +: PRIO_W], rd_group);
    assign rd_sub_o  = sub_of(s_q.prio[rd_id*PRIO_W +: PRIO_W], rd_group);
    assign grp_o     = s_q.grp;

    logic [NUM_IRQ-1:0] en_q, pend_q, act_q;
    assign en_q   = s_q.en;
    assign pend_q = s_q.pend;
    assign act_q  = s_q.act;
endmodule

// File: rtl/irq_arb_chk.sv
module irq_arb_chk #(
    parameter int NUM_IRQ = 8,
    localparam int ID_W   = $clog2(NUM_IRQ)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               ack_i,
    input logic               done_i,
    input logic               req_o,
    input logic [ID_W-1:0]    req_id_o,
    input logic [NUM_IRQ-1:0] en_q,
    input logic [NUM_IRQ-1:0] pend_q,
    input logic [NUM_IRQ-1:0] act_q,
    input logic [2:0]         grp_o
);
    AST_REQ_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
        req_o |-> (en_q[req_id_o] && pend_q[req_id_o])); // R3

    AST_ACK_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && req_o) |=> (act_q[$past(req_id_o)] && !pend_q[$past(req_id_o)])); // R6

    AST_ACK_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && !req_o && !done_i) |=> $stable(act_q)); // R6

    AST_NO_NEST_G0: assert property (@(posedge clk) disable iff (!rst_n)
        ((grp_o == 3'd0) && (act_q != '0)) |-> !req_o); // R8

    AST_GROUP_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        grp_o <= 3'd4); // R10

    AST_DONE_RETIRES: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && !ack_i && (act_q != '0)) |=> ($countones(act_q) + 1 == $countones($past(act_q)))); // R9
endmodule

bind irq_arb irq_arb_chk #(.NUM_IRQ(NUM_IRQ)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ack_i    (ack_i),
    .done_i   (done_i),
    .req_o    (req_o),
    .req_id_o (req_id_o),
    .en_q     (en_q),
    .pend_q   (pend_q),
    .act_q    (act_q),
    .grp_o    (grp_o)
);

// File: tb/irq_arb_bench.sv
module irq_arb_bench;
    localparam int N  = 8;
    localparam int IW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  irq_i = '0;
    logic          wr_en = 1'b0;
    logic [2:0]    wr_op = '0;
    logic [IW-1:0] wr_id = '0;
    logic [7:0]    wr_data = '0;
    logic [IW-1:0] rd_id = '0;
    logic [2:0]    rd_group = '0;
    logic          rd_en_o, rd_pend_o, rd_act_o;
    logic [3:0]    rd_pre_o, rd_sub_o;
    logic [2:0]    grp_o;
    logic          req_o;
    logic [IW-1:0] req_id_o;
    logic          ack_i = 1'b0;
    logic          done_i = 1'b0;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    irq_arb #(.NUM_IRQ(N)) u_irq_arb (.*);

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wop(input int op, input int id, input int data);
        @(negedge clk);
        wr_en = 1'b1; wr_op = 3'(op); wr_id = IW'(id); wr_data = 8'(data);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_prio(input int id, input int pre, input int sub);
        wop(4, id, (sub << 4) | pre);
    endtask

    task automatic ack();
        @(negedge clk); ack_i = 1'b1;
        @(negedge clk); ack_i = 1'b0;
    endtask

    task automatic done();
        @(negedge clk); done_i = 1'b1;
        @(negedge clk); done_i = 1'b0;
    endtask

    task automatic rd(input int id, input int g);
        rd_id = IW'(id); rd_group = 3'(g); #0.5;
    endtask

    task automatic t_reset();
        rd(0, 0);
        chk("R1 req", int'(req_o), 0);
        chk("R1 grp", int'(grp_o), 0);
        chk("R1 state", {rd_en_o, rd_pend_o, rd_act_o, rd_pre_o, rd_sub_o}, 0);
    endtask

    task automatic t_regs();
        wop(0, 3, 0); rd(3, 0);
        chk("R2 enable", int'(rd_en_o), 1);
        wop(2, 3, 0); rd(3, 0);
        chk("R2 setpend", int'(rd_pend_o), 1);
        chk("R2 req", int'(req_o), 1);
        wop(3, 3, 0); rd(3, 0);
        chk("R2 clrpend", int'(rd_pend_o), 0);
        wop(1, 3, 0); rd(3, 0);
        chk("R2 disable", int'(rd_en_o), 0);
    endtask

    task automatic t_disabled();
        @(negedge clk); irq_i[5] = 1'b1;
        @(negedge clk); irq_i[5] = 1'b0;
        rd(5, 0);
        chk("R3 pend while disabled", int'(rd_pend_o), 1);
        chk("R3 no req", int'(req_o), 0);
        wop(0, 5, 0);
        chk("R3 req after enable", int'(req_o), 1);
        chk("R3 id", int'(req_id_o), 5);
        wop(3, 5, 0);
        wop(1, 5, 0);
    endtask

    task automatic t_rank();
        wop(5, 0, 2);
        chk("R10 grp=2", int'(grp_o), 2);
        set_prio(1, 1, 2);
        set_prio(2, 1, 1);
        set_prio(4, 1, 1);
        set_prio(3, 0, 3);
        rd(1, 2);
        chk("R5 pre g2", int'(rd_pre_o), 1);
        chk("R5 sub g2", int'(rd_sub_o), 2);
        rd(1, 4);
        chk("R5 pre g4", int'(rd_pre_o), 6);
        chk("R5 sub g4", int'(rd_sub_o), 0);
        rd(1, 0);
        chk("R5 pre g0", int'(rd_pre_o), 0);
        chk("R5 sub g0", int'(rd_sub_o), 6);
        for (int i = 1; i <= 4; i++) begin wop(0, i, 0); wop(2, i, 0); end
        chk("R4 preempt first", int'(req_id_o), 3);
        wop(3, 3, 0);
        chk("R4 sub tie lowest", int'(req_id_o), 2);
        wop(3, 2, 0);
        chk("R4 next", int'(req_id_o), 4);
        wop(3, 4, 0);
        chk("R4 last", int'(req_id_o), 1);
        wop(3, 1, 0);
        chk("R4 empty", int'(req_o), 0);
    endtask

    task automatic t_nest();
        set_prio(0, 2, 0);
        set_prio(6, 1, 3);
        set_prio(7, 1, 0);
        wop(0, 0, 0); wop(0, 6, 0); wop(0, 7, 0);
        wop(2, 0, 0);
        chk("R6 req", int'(req_o), 1);
        ack(); rd(0, 0);
        chk("R6 active", int'(rd_act_o), 1);
        chk("R6 pend clr", int'(rd_pend_o), 0);
        ack(); rd(0, 0);
        chk("R6 ignored ack", int'(rd_act_o), 1);
        rd(1, 0);
        chk("R6 ignored ack other", int'(rd_act_o), 0);
        wop(2, 6, 0);
        chk("R7 lower nests", int'(req_o), 1);
        chk("R7 id6", int'(req_id_o), 6);
        ack();
        wop(2, 7, 0);
        chk("R7 equal blocked", int'(req_o), 0);
        done(); rd(6, 0);
        chk("R9 newest retired", int'(rd_act_o), 0);
        rd(0, 0);
        chk("R9 older kept", int'(rd_act_o), 1);
        chk("R7 req after retire", int'(req_o), 1);
        chk("R7 id7", int'(req_id_o), 7);
        ack(); done(); rd(7, 0);
        chk("R9 7 retired", int'(rd_act_o), 0);
        rd(0, 0);
        chk("R9 0 still", int'(rd_act_o), 1);
        done(); rd(0, 0);
        chk("R9 0 retired", int'(rd_act_o), 0);
    endtask

    task automatic t_group();
        wop(5, 0, 0);
        wop(2, 6, 0);
        chk("R8 idle req", int'(req_o), 1);
        ack();
        wop(2, 7, 0);
        chk("R8 no nest g0", int'(req_o), 0);
        wop(5, 0, 1);
        chk("R10 g1 equal", int'(req_o), 0);
        wop(5, 0, 3);
        chk("R10 g3 nests", int'(req_o), 1);
        chk("R10 g3 id", int'(req_id_o), 7);
        wop(5, 0, 5);
        chk("R10 illegal ignored", int'(grp_o), 3);
        ack(); done(); done();
        rd(6, 0);
        chk("R9 unwound 6", int'(rd_act_o), 0);
        rd(7, 0);
        chk("R9 unwound 7", int'(rd_act_o), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_regs();
        t_disabled();
        t_rank();
        t_nest();
        t_group();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule